// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-mapped master for the two-wire Ethernet management bus: a clock output (MDC) and a data line that is bidirectional at the pad (MDIO, given here as separate out, output-enable and in signals). A host writes a mode word, a PHY/register address word and a 16-bit write-data word, then starts a transaction through a command word. It polls a busy flag until the frame has gone out and, after a read, picks up the 16 bits returned by the PHY from a read-data word.

Both Clause 22 and Clause 45 framing are supported, and one mode bit picks between them. The mode bit also changes the meaning of the command opcodes. In Clause 45 the address cycle, the write cycle and the read cycle are each a separate host command. During an address cycle the write-data word carries the register address. MDC comes from the 100 MHz reference clock through a divider held in the mode word. The PHY address, register or device number and payload are all captured when a frame starts, so the host may rewrite the registers while the frame is still going out.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at byte offsets 0x40 (mode), 0x44 (address), 0x48 (write data), 0x4C (read data) and 0x50 (command). Mode reads back divisor in bits 7:0 and clause select in bit 8. Address reads back the PHY address in bits 12:8 and the register/device number in bits 4:0, with all other bits 0. Write data reads back bits 15:0.
- R2: After reset, busy reads 0, MDC is low, MDIO is not driven, and the mode word reads 0x014 (Clause 22, divisor 20, which gives 2.5 MHz from 100 MHz).
- R3: A write of the command word with bit 8 set and a valid opcode in bits 1:0 starts a frame. Command bit 16 (busy) reads 1 from the next cycle until the frame ends. MDC stays low and MDIO stays undriven whenever no frame is running.
- R4: Each MDC half period lasts the divisor value in reference cycles, with a divisor of 0 acting as 1, so one MDC period is 2×divisor cycles. MDIO changes only after a falling MDC edge and is sampled on the rising edge.
- R5: Each frame is 64 bits, MSB first: 32 ones, a 2-bit start, a 2-bit operation, the 5-bit PHY address, the 5-bit register/device number, a 2-bit turnaround (10 on driven frames) and 16 data bits.
- R6: With mode bit 8 = 0, the start field is 01. Opcode 0 sends a read (operation 10). Opcode 1 sends a write (operation 01) whose data is the write-data word.
- R7: With mode bit 8 = 1, the start field is 00. Opcode 0 sends an address frame (operation 00) carrying the write-data word. Opcode 1 sends a write (operation 01). Opcode 2 sends a read (operation 11).
- R8: On read frames, the master releases MDIO from the turnaround through the last data bit. It captures the 16 data bits MSB first into read-data bits 15:0. Write and address frames leave the read-data word unchanged.
- R9: A start written while busy is ignored: no second frame follows, and the running frame completes unchanged.
- R10: A start with an opcode that is undefined for the current mode (2 or 3 in Clause 22, 3 in Clause 45) never sets busy and produces no MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte offset for reads and writes |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Data line as seen at the pad |

## Verification
The bench keeps the default parameters: a 32-bit preamble, an 8-bit divisor field and a reset divisor of 20. It changes the divisor through the mode word to 2, 3 and 0, which keeps most frames at a few hundred cycles and brings the minimum-divisor case within reach. One frame runs at the reset divisor to confirm the 2.5 MHz rate. A PHY model answers reads with known words, and a scoreboard compares every shifted frame bit by bit, including the output-enable pattern.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;
  localparam int FRAME_W = 32;  // bits after the preamble

  // control -> datapath strobes
  typedef struct packed {
    logic       load;
    logic       shift;
    logic       capture;
    logic       rdFrame;
    logic [1:0] st;
    logic [1:0] op;
  } mdio_strb_t;
endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addrWr,
  input  logic        dataWr,
  input  logic [15:0] wrVal,
  input  logic        mdioIn,
  input  mdio_strb_t  strb,
  output logic        txBit,
  output logic [4:0]  phyQ,
  output logic [4:0]  regQ,
  output logic [15:0] wdataQ,
  output logic [15:0] rdDataQ
);
  logic [FRAME_W-1:0] frameSr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phyQ    <= '0;
      regQ    <= '0;
      wdataQ  <= '0;
      rdDataQ <= '0;
      frameSr <= '0;
    end else begin
      if (addrWr) begin
        phyQ <= wrVal[12:8];
        regQ <= wrVal[4:0];
      end
      if (dataWr) wdataQ <= wrVal;
      if (strb.load)
        frameSr <= {strb.st, strb.op, phyQ, regQ,
                    strb.rdFrame ? 2'b11 : 2'b10,
                    strb.rdFrame ? 16'hFFFF : wdataQ};
      else if (strb.shift)
        frameSr <= {frameSr[FRAME_W-2:0], 1'b1};
      if (strb.capture) rdDataQ <= {rdDataQ[14:0], mdioIn};
    end
  end

  assign txBit = frameSr[FRAME_W-1];

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.load && (strb.shift || strb.capture))); // R3
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modeWr,
  input  logic [8:0]       modeVal,
  input  logic             startReq,
  input  logic [1:0]       cmdOpc,
  input  logic             txBit,
  output logic             busy,
  output logic             modeC45,
  output logic [DIV_W-1:0] modeDiv,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output mdio_strb_t       strb
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DAT_BIT  = CNT_W'(PRE_LEN + 16);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_LEN);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] halfCnt, divLat;
  logic             rdLat, mdcQ;
  logic             opValid, opRead, launch, halfTick, endNow;
  logic [1:0]       stSel, opSel;

  always_comb begin
    opValid = 1'b1;
    opRead  = 1'b0;
    stSel   = modeC45 ? 2'b00 : 2'b01;
    opSel   = 2'b00;
    if (!modeC45) begin
      case (cmdOpc)
        2'd0:    begin opSel = 2'b10; opRead = 1'b1; end
        2'd1:    opSel = 2'b01;
        default: opValid = 1'b0;
      endcase
    end else begin
      case (cmdOpc)
        2'd0:    opSel = 2'b00;
        2'd1:    opSel = 2'b01;
        2'd2:    begin opSel = 2'b11; opRead = 1'b1; end
        default: opValid = 1'b0;
      endcase
    end
  end

  assign launch   = startReq && (state == ST_IDLE) && opValid;
  assign halfTick = (state == ST_RUN) && (halfCnt == divLat - 1'b1);
  assign endNow   = halfTick && mdcQ && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeC45 <= 1'b0;
      modeDiv <= DIV_W'(DIV_RST);
      state   <= ST_IDLE;
      bitCnt  <= '0;
      halfCnt <= '0;
      divLat  <= DIV_W'(1);
      rdLat   <= 1'b0;
      mdcQ    <= 1'b0;
    end else begin
      if (modeWr) begin
        modeC45 <= modeVal[8];
        modeDiv <= modeVal[DIV_W-1:0];
      end
      if (launch) begin
        state   <= ST_RUN;
        bitCnt  <= '0;
        halfCnt <= '0;
        mdcQ    <= 1'b0;
        rdLat   <= opRead;
        divLat  <= (modeDiv == '0) ? DIV_W'(1) : modeDiv;
      end else if (state == ST_RUN) begin
        if (halfTick) begin
          halfCnt <= '0;
          mdcQ    <= ~mdcQ;
          if (mdcQ) begin
            if (bitCnt == LAST_BIT) state <= ST_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.load    = launch;
    strb.shift   = halfTick && mdcQ && (bitCnt >= PRE_END);
    strb.capture = halfTick && !mdcQ && rdLat && (bitCnt >= DAT_BIT);
    strb.rdFrame = opRead;
    strb.st      = stSel;
    strb.op      = opSel;
  end

  assign busy    = (state == ST_RUN);
  assign mdc     = mdcQ;
  assign mdioOut = busy && ((bitCnt < PRE_END) ? 1'b1 : txBit);
  assign mdioOe  = busy && !(rdLat && (bitCnt >= TA_BIT));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdioOe)); // R3
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$fell(mdcQ)) |-> $stable(mdioOut)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startReq && !endNow) |=> (busy && $stable(rdLat) && $stable(divLat))); // R9
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && !opValid) |=> !busy); // R10
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  busAddr,
  input  logic        busWrite,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_strb_t       strb;
  logic             busy, modeC45, txBit;
  logic [DIV_W-1:0] modeDiv;
  logic [4:0]       phyQ, regQ;
  logic [15:0]      wdataQ, rdDataQ;
  logic             unusedWd;

  assign unusedWd = ^busWdata;

  mdio_ctrl #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .modeWr  (busWrite && busAddr == OFS_MODE),
    .modeVal (busWdata[8:0]),
    .startReq(busWrite && busAddr == OFS_CMD && busWdata[8]),
    .cmdOpc  (busWdata[1:0]),
    .txBit   (txBit),
    .busy    (busy),
    .modeC45 (modeC45),
    .modeDiv (modeDiv),
    .mdc     (mdc),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe),
    .strb    (strb)
  );

  mdio_dp i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .addrWr (busWrite && busAddr == OFS_ADDR),
    .dataWr (busWrite && busAddr == OFS_WDATA),
    .wrVal  (busWdata[15:0]),
    .mdioIn (mdioIn),
    .strb   (strb),
    .txBit  (txBit),
    .phyQ   (phyQ),
    .regQ   (regQ),
    .wdataQ (wdataQ),
    .rdDataQ(rdDataQ)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_MODE:  busRdata = 32'({modeC45, 8'(modeDiv)});
      OFS_ADDR:  busRdata = {19'd0, phyQ, 3'd0, regQ};
      OFS_WDATA: busRdata = {16'd0, wdataQ};
      OFS_RDATA: busRdata = {16'd0, rdDataQ};
      OFS_CMD:   busRdata = {15'd0, busy, 16'd0};
      default:   busRdata = '0;
    endcase
  end

  AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |-> !mdioOe); // R8
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0, failures = 0;
  int nBits = 0, frameCnt = 0, riseCnt = 0;
  longint cycle = 0, lastRise = 0, lastPeriod = 0;
  logic [63:0] curBits, curOe;
  logic [15:0] phyReply = 16'h0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: presents reply bits during the data window of a frame
  always_comb mdioIn = (nBits >= 48 && nBits < 64) ? phyReply[63-nBits] : 1'b1;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(posedge mdc) begin
    curBits = {curBits[62:0], mdioOut};
    curOe   = {curOe[62:0], mdioOe};
    riseCnt++;
    lastPeriod = cycle - lastRise;
    lastRise = cycle;
    nBits++;
    if (nBits == 64) begin
      frameCnt++;
      nBits = 0;
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected frame", curBits, 64'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check((((curBits ^ e.bits) & e.oe) == 64'h0), {e.req, " bits"}, curBits, e.bits);
        check(curOe == e.oe, {e.req, " oe"}, curOe, e.oe);
      end
    end
  end

  function automatic exp_t mkExp(bit c45, logic [1:0] opc, logic [4:0] phy,
                                 logic [4:0] ra, logic [15:0] data, string req);
    exp_t e;
    logic [1:0] st, op;
    bit rd;
    st = c45 ? 2'b00 : 2'b01;
    rd = c45 ? (opc == 2'd2) : (opc == 2'd0);
    if (!c45) op = (opc == 2'd0) ? 2'b10 : 2'b01;
    else op = (opc == 2'd0) ? 2'b00 : (opc == 2'd1) ? 2'b01 : 2'b11;
    e.bits = {32'hFFFF_FFFF, st, op, phy, ra, rd ? 2'b00 : 2'b10, rd ? 16'h0 : data};
    e.oe   = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    e.req  = req;
    return e;
  endfunction

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrite = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      busRd(8'h50, d);
      if (!d[16]) return;
    end
    check(1'b0, "R3 busy never cleared", 64'h1, 64'h0);
  endtask

  task automatic doFrame(bit c45, logic [7:0] div, logic [1:0] opc, logic [4:0] phy,
                         logic [4:0] ra, logic [15:0] data, string req);
    logic [31:0] d;
    busWr(8'h40, {23'd0, c45, div});
    busWr(8'h44, {19'd0, phy, 3'd0, ra});
    busWr(8'h48, {16'd0, data});
    expQ.push_back(mkExp(c45, opc, phy, ra, data, req));
    busWr(8'h50, {23'd0, 1'b1, 6'd0, opc});
    busRd(8'h50, d);
    check(d[16] == 1'b1, "R3 busy after start", 64'(d[16]), 64'h1);
    waitIdle();
  endtask

  initial begin
    logic [31:0] d;
    int fc;
    int rc;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(mdc == 1'b0 && mdioOe == 1'b0, "R2 mdc/oe at reset", {mdc, mdioOe}, 64'h0);
    rst_n = 1'b1;
    busRd(8'h50, d); check(d[16] == 1'b0, "R2 busy at reset", 64'(d), 64'h0);
    busRd(8'h40, d); check(d == 32'h14, "R2 mode default", 64'(d), 64'h14);
    // R1 register readback
    busWr(8'h44, 32'hFFFF_FFFF);
    busRd(8'h44, d); check(d == 32'h1F1F, "R1 address readback", 64'(d), 64'h1F1F);
    busWr(8'h44, 32'h0000_1A07);
    busRd(8'h44, d); check(d == 32'h1A07, "R1 address fields", 64'(d), 64'h1A07);
    busWr(8'h48, 32'h1234_C0DE);
    busRd(8'h48, d); check(d == 32'hC0DE, "R1 wdata readback", 64'(d), 64'hC0DE);
    busWr(8'h40, 32'h0000_0105);
    busRd(8'h40, d); check(d == 32'h105, "R1 mode readback", 64'(d), 64'h105);

    // Clause 22 write, R5 R6, period R4
    doFrame(1'b0, 8'd2, 2'd1, 5'h05, 5'h11, 16'hA5C3, "R6 c22 write");
    check(lastPeriod == 4, "R4 period div2", 64'(lastPeriod), 64'd4);
    // Clause 22 read, R8
    phyReply = 16'hBEEF;
    doFrame(1'b0, 8'd2, 2'd0, 5'h01, 5'h02, 16'h0, "R5 c22 read");
    busRd(8'h4C, d); check(d == 32'hBEEF, "R8 read capture", 64'(d), 64'hBEEF);
    doFrame(1'b0, 8'd2, 2'd1, 5'h1F, 5'h00, 16'h0001, "R6 c22 write2");
    busRd(8'h4C, d); check(d == 32'hBEEF, "R8 write keeps rdata", 64'(d), 64'hBEEF);

    // Clause 45, R7
    doFrame(1'b1, 8'd3, 2'd0, 5'h03, 5'h07, 16'h1234, "R7 c45 address");
    check(lastPeriod == 6, "R4 period div3", 64'(lastPeriod), 64'd6);
    busRd(8'h4C, d); check(d == 32'hBEEF, "R8 address keeps rdata", 64'(d), 64'hBEEF);
    doFrame(1'b1, 8'd3, 2'd1, 5'h03, 5'h07, 16'h5678, "R7 c45 write");
    phyReply = 16'h0F0F;
    doFrame(1'b1, 8'd3, 2'd2, 5'h03, 5'h07, 16'h0, "R7 c45 read");
    busRd(8'h4C, d); check(d == 32'h0F0F, "R8 c45 read capture", 64'(d), 64'h0F0F);

    // R9 start while busy
    fc = frameCnt;
    busWr(8'h40, 32'h0000_0002);
    busWr(8'h44, 32'h0000_0904);
    busWr(8'h48, 32'h0000_3C3C);
    expQ.push_back(mkExp(1'b0, 2'd1, 5'h09, 5'h04, 16'h3C3C, "R9 running frame"));
    busWr(8'h50, 32'h0000_0101);
    repeat (30) @(negedge clk);
    busWr(8'h48, 32'h0000_FFFF);
    busWr(8'h50, 32'h0000_0100);
    waitIdle();
    repeat (20) @(negedge clk);
    check(frameCnt == fc + 1, "R9 single frame", 64'(frameCnt - fc), 64'd1);
    busRd(8'h4C, d); check(d == 32'h0F0F, "R9 no read ran", 64'(d), 64'h0F0F);

    // R10 undefined opcodes
    rc = riseCnt;
    busWr(8'h40, 32'h0000_0002);
    busWr(8'h50, 32'h0000_0102);
    busRd(8'h50, d); check(d[16] == 1'b0, "R10 c22 op2 no busy", 64'(d), 64'h0);
    busWr(8'h50, 32'h0000_0103);
    busRd(8'h50, d); check(d[16] == 1'b0, "R10 c22 op3 no busy", 64'(d), 64'h0);
    busWr(8'h40, 32'h0000_0102);
    busWr(8'h50, 32'h0000_0103);
    busRd(8'h50, d); check(d[16] == 1'b0, "R10 c45 op3 no busy", 64'(d), 64'h0);
    repeat (40) @(negedge clk);
    check(riseCnt == rc, "R10 no mdc edges", 64'(riseCnt - rc), 64'd0);

    // R4 divisor 0 acts as 1, and reset divisor 20
    doFrame(1'b0, 8'd0, 2'd1, 5'h0A, 5'h15, 16'h8001, "R4 div0 frame");
    check(lastPeriod == 2, "R4 period div0", 64'(lastPeriod), 64'd2);
    doFrame(1'b0, 8'd20, 2'd1, 5'h11, 5'h0A, 16'h7E81, "R4 div20 frame");
    check(lastPeriod == 40, "R4 period div20", 64'(lastPeriod), 64'd40);
    check(expQ.size() == 0, "R5 all frames seen", 64'(expQ.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog R3 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule